// File: doc/BRIEF.md
# Wilkinson Conversion Counter Capture

This block is the digital side of a single-slope conversion that serves many sampling channels at once. Each channel holds a row of analog cells, and each cell has a comparator that goes high once a shared voltage ramp passes the cell's stored level. When the host issues a start with a mask of triggered channels, the block clears and runs one Gray-coded conversion counter. It raises a ramp-run line for each masked channel and arms every cell of those channels. Each armed cell latches the counter value on its comparator's first rising edge.

The host picks the resolution with a mode field: 11, 9 or 8 bits. The run lasts 2^N counts for the chosen N. On the last count, any cell that has not fired takes the full-scale code. Each converted channel then gets a done flag and a one-cycle re-arm pulse, so it can record a new event at once while its codes wait to be read. The ramp generators, comparators and oscillator are outside the block and appear only as stimulus.

The controller has two states. IDLE waits for an accepted start. On the transition IDLE to COUNT (start with a non-empty mask), the counter is cleared, the mode and mask are taken, and the masked cells are armed. COUNT counts up once per clock. On the transition COUNT to IDLE (the terminal count for the mode), unfired cells are filled, done and re-arm are set, and the ramp lines drop. COUNT ignores any start.

Top module: `wk_capture`

## Requirements
- R1: After reset all ramp_go, done and rearm bits are 0 and every cell code is 0.
- R2: A start seen in IDLE with a non-zero chan_sel sets ramp_go to that mask from the next cycle. It clears done for those channels. ramp_go falls in the same cycle that done rises.
- R3: The counter is 0 in the first cycle after the accepted start and rises by one each cycle. A cell whose comparator rises while the count is k stores the Gray code k ^ (k >> 1), with bit 0 as the least significant bit of the code field.
- R4: Only the first rising comparator edge after the start is captured, and later edges leave the code alone. A comparator that is already high at the start is not a rising edge.
- R5: A cell whose comparator has not risen by the terminal count stores the full-scale code, which is the Gray code of 2^N - 1.
- R6: res_mode 2'b00 and 2'b11 select 11 bits (2048 counts), 2'b01 selects 9 bits (512 counts) and 2'b10 selects 8 bits (256 counts). done stays low through the last count and rises right after it.
- R7: On completion, done sets for each converted channel and stays set until a later start selects that channel again. rearm pulses high for exactly one cycle, together with done.
- R8: Channels not in the accepted mask keep their codes and done flags, and their ramp_go stays low, whatever their comparators do.
- R9: A start during COUNT is ignored, and so is a start with an all-zero mask. Neither changes ramp_go, done, the count length or any code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion start request |
| chan_sel | input | NUM_CH | Channels to convert, sampled with start |
| res_mode | input | 2 | Resolution select, sampled with start |
| cmp | input | NUM_CH*NUM_CELLS | Cell comparator outputs, index ch*NUM_CELLS+cell |
| ramp_go | output | NUM_CH | Ramp run line per channel |
| code | output | NUM_CH*NUM_CELLS*CW | Captured Gray codes, CW bits per cell in cmp order |
| done | output | NUM_CH | Conversion-complete flag per channel |
| rearm | output | NUM_CH | One-cycle release pulse per channel |

## Verification
The bench builds the block with two channels of four cells and keeps the full 11-bit counter. Every cell can therefore be checked on each run, and complete 2048-count conversions stay short. The table of runs covers all four mode codes and single- and dual-channel masks. It includes cells that fire at count 0, at the last count and never. Directed runs cover comparator glitches, a comparator already high at the start, a start during a run and a start with an empty mask.

// File: rtl/wk_pkg.sv
package wk_pkg;

    typedef enum logic [1:0] {
        RES_FULL = 2'b00,
        RES_MID  = 2'b01,
        RES_LOW  = 2'b10,
        RES_ALT  = 2'b11
    } res_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/wk_gray_counter.sv
module wk_gray_counter
    import wk_pkg::*;
#(
    parameter int CW    = 11,
    parameter int MID_W = 9,
    parameter int LOW_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          run_i,
    input  logic [1:0]    mode_i,
    output logic [CW-1:0] gray_o,
    output logic          last_o
);

    localparam logic [CW-1:0] LIM_FULL = {CW{1'b1}};
    localparam logic [CW-1:0] LIM_MID  = CW'((1 << MID_W) - 1);
    localparam logic [CW-1:0] LIM_LOW  = CW'((1 << LOW_W) - 1);

    logic [CW-1:0] bin_q;
    logic [CW-1:0] limit;

    always_comb begin
        unique case (res_mode_e'(mode_i))
            RES_MID:  limit = LIM_MID;
            RES_LOW:  limit = LIM_LOW;
            RES_FULL: limit = LIM_FULL;
            RES_ALT:  limit = LIM_FULL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q <= '0;
        end else if (clear_i) begin
            bin_q <= '0;
        end else if (run_i) begin
            bin_q <= bin_q + 1'b1;
        end
    end

    assign gray_o = bin_q ^ (bin_q >> 1);
    assign last_o = (bin_q == limit);

    // R6: the count never passes the terminal value of the mode
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bin_q <= limit);

    // R3: consecutive counts differ in exactly one Gray bit
    p_gray_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !clear_i) |=> ($countones(gray_o ^ $past(gray_o)) == 1));

endmodule

// File: rtl/wk_cell.sv
module wk_cell #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic          finish_i,
    input  logic          cmp_i,
    input  logic [CW-1:0] gray_i,
    output logic [CW-1:0] code_o
);

    logic armed_q;
    logic cmp_q;
    logic rise;

    assign rise = cmp_i && !cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cmp_q   <= 1'b0;
            code_o  <= '0;
        end else begin
            cmp_q <= cmp_i;
            if (arm_i) begin
                armed_q <= 1'b1;
            end else if (armed_q && (rise || finish_i)) begin
                code_o  <= gray_i;
                armed_q <= 1'b0;
            end
        end
    end

    // R4: a cell that is not armed keeps its code
    p_code_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |=> $stable(code_o));

    // R5: the terminal count always leaves the cell disarmed
    p_finish_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (finish_i && !arm_i) |=> !armed_q);

endmodule

// File: rtl/wk_channel.sv
module wk_channel #(
    parameter int NUM_CELLS = 64,
    parameter int CW        = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    arm_i,
    input  logic                    finish_i,
    input  logic [NUM_CELLS-1:0]    cmp_i,
    input  logic [CW-1:0]           gray_i,
    output logic [NUM_CELLS*CW-1:0] code_o,
    output logic                    ramp_o,
    output logic                    done_o,
    output logic                    rearm_o
);

    for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
        wk_cell #(.CW(CW)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm_i    (arm_i),
            .finish_i (finish_i),
            .cmp_i    (cmp_i[g]),
            .gray_i   (gray_i),
            .code_o   (code_o[g*CW +: CW])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_o  <= 1'b0;
            done_o  <= 1'b0;
            rearm_o <= 1'b0;
        end else begin
            rearm_o <= 1'b0;
            if (arm_i) begin
                ramp_o <= 1'b1;
                done_o <= 1'b0;
            end else if (finish_i) begin
                ramp_o  <= 1'b0;
                done_o  <= 1'b1;
                rearm_o <= 1'b1;
            end
        end
    end

    // R7: the release pulse lasts one cycle
    p_rearm_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_o |=> !rearm_o);

    // R7: the release pulse comes with the done flag
    p_rearm_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_o |-> done_o);

    // R2: a ramp never runs on a channel that is flagged done
    p_ramp_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ramp_o && done_o));

endmodule

// File: rtl/wk_capture.sv
module wk_capture
    import wk_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_CELLS = 64,
    parameter int CW        = 11,
    parameter int MID_W     = 9,
    parameter int LOW_W     = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [NUM_CH-1:0]              chan_sel,
    input  logic [1:0]                     res_mode,
    input  logic [NUM_CH*NUM_CELLS-1:0]    cmp,
    output logic [NUM_CH-1:0]              ramp_go,
    output logic [NUM_CH*NUM_CELLS*CW-1:0] code,
    output logic [NUM_CH-1:0]              done,
    output logic [NUM_CH-1:0]              rearm
);

    localparam int ROW_W = NUM_CELLS * CW;

    ctl_state_e    state_q, state_d;
    logic [1:0]    mode_q;
    logic [CW-1:0] gray;
    logic          last;
    logic          accept;
    logic          finish;
    logic          cnt_run;
    logic [NUM_CH-1:0] arm_ch;
    logic [NUM_CH-1:0] fin_ch;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and control outputs
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        finish  = 1'b0;
        cnt_run = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && (|chan_sel)) begin
                    accept  = 1'b1;
                    state_d = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (last) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    cnt_run = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 2'b00;
        end else if (accept) begin
            mode_q <= res_mode;
        end
    end

    assign arm_ch = {NUM_CH{accept}} & chan_sel;
    assign fin_ch = {NUM_CH{finish}} & ramp_go;

    wk_gray_counter #(.CW(CW), .MID_W(MID_W), .LOW_W(LOW_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .run_i   (cnt_run),
        .mode_i  (mode_q),
        .gray_o  (gray),
        .last_o  (last)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        wk_channel #(.NUM_CELLS(NUM_CELLS), .CW(CW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm_i    (arm_ch[c]),
            .finish_i (fin_ch[c]),
            .cmp_i    (cmp[c*NUM_CELLS +: NUM_CELLS]),
            .gray_i   (gray),
            .code_o   (code[c*ROW_W +: ROW_W]),
            .ramp_o   (ramp_go[c]),
            .done_o   (done[c]),
            .rearm_o  (rearm[c])
        );
    end

    // R2: an accepted start drives the ramps to the requested mask
    p_start_ramp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && (|chan_sel)) |=> (ramp_go == $past(chan_sel)));

    // R9: a start during a run leaves the ramps alone
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !last) |=> $stable(ramp_go));

    // R8: ramps only run while counting
    p_ramp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (ramp_go == '0));

endmodule

// File: tb/tb_wk_capture.sv
module tb_wk_capture;

    localparam int NCH   = 2;
    localparam int NCELL = 4;
    localparam int CW    = 11;
    localparam int NC    = NCH * NCELL;
    localparam int NEVER = 4095;
    localparam int NV    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NCH-1:0] chan_sel = '0;
    logic [1:0] res_mode = 2'b00;
    logic [NC-1:0] cmp = '0;
    logic [NCH-1:0] ramp_go;
    logic [NC*CW-1:0] code;
    logic [NCH-1:0] done;
    logic [NCH-1:0] rearm;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int exp_code [NC];
    logic [NCH-1:0] exp_done = '0;

    // run table: mode, mask, per-cell comparator rise count (cell 0 in low bits)
    localparam logic [1:0]      V_MODE [NV] = '{2'b10, 2'b01, 2'b00, 2'b11};
    localparam logic [NCH-1:0]  V_SEL  [NV] = '{2'b11, 2'b01, 2'b10, 2'b11};
    localparam logic [NC*12-1:0] V_TGT [NV] = '{
        {12'd254, 12'hFFF, 12'd200, 12'd17, 12'd255, 12'd100, 12'd1, 12'd0},
        {12'd3, 12'd3, 12'd3, 12'd3, 12'hFFF, 12'd5, 12'd511, 12'd300},
        {12'd1500, 12'd0, 12'd1024, 12'd2047, 12'd7, 12'd7, 12'd7, 12'd7},
        {12'd777, 12'd1, 12'd512, 12'hFFF, 12'd2000, 12'd1023, 12'd64, 12'd2046}
    };

    wk_capture #(.NUM_CH(NCH), .NUM_CELLS(NCELL), .CW(CW)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .chan_sel (chan_sel),
        .res_mode (res_mode),
        .cmp      (cmp),
        .ramp_go  (ramp_go),
        .code     (code),
        .done     (done),
        .rearm    (rearm)
    );

    always #5 clk = ~clk;

    function automatic int gray(input int v);
        return v ^ (v >> 1);
    endfunction

    function automatic int lim(input logic [1:0] m);
        case (m)
            2'b01:   return 511;
            2'b10:   return 255;
            default: return 2047;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_codes(input logic [NCH-1:0] s, input int mx);
        for (int c = 0; c < NC; c++) begin
            if (!s[c / NCELL])
                chk("R8 unselected code kept", 32'(code[c*CW +: CW]), 32'(exp_code[c]));
            else if (exp_code[c] == gray(mx))
                chk("R5 full-scale or last-count code", 32'(code[c*CW +: CW]), 32'(exp_code[c]));
            else
                chk("R3 captured gray code", 32'(code[c*CW +: CW]), 32'(exp_code[c]));
        end
        chk("R8 done flags", 32'(done), 32'(exp_done));
    endtask

    task automatic run_vec(input logic [1:0] m, input logic [NCH-1:0] s, input logic [NC*12-1:0] t);
        int mx;
        mx = lim(m);
        @(negedge clk);
        cmp = '0;
        chan_sel = s;
        res_mode = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chan_sel = '0;
        chk("R2 ramp follows mask", 32'(ramp_go), 32'(s));
        chk("R2 done cleared at start", 32'(done & s), 32'd0);
        for (int cyc = 0; cyc <= mx; cyc++) begin
            if (cyc > 0) @(negedge clk);
            for (int c = 0; c < NC; c++)
                if (int'(t[c*12 +: 12]) <= cyc) cmp[c] = 1'b1;
            if (cyc == mx) chk("R6 done low through last count", 32'(done & s), 32'd0);
        end
        @(negedge clk);
        chk("R6 done right after last count", 32'(done & s), 32'(s));
        chk("R7 rearm pulse", 32'(rearm), 32'(s));
        chk("R2 ramp drops with done", 32'(ramp_go), 32'd0);
        for (int c = 0; c < NC; c++) begin
            int tv;
            tv = int'(t[c*12 +: 12]);
            if (s[c / NCELL]) exp_code[c] = gray(tv <= mx ? tv : mx);
        end
        exp_done = exp_done | s;
        check_codes(s, mx);
        @(negedge clk);
        chk("R7 rearm one cycle", 32'(rearm), 32'd0);
        chk("R7 done held", 32'(done), 32'(exp_done));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) exp_code[c] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ramp at reset", 32'(ramp_go), 32'd0);
        chk("R1 done at reset", 32'(done), 32'd0);
        chk("R1 rearm at reset", 32'(rearm), 32'd0);
        chk("R1 codes at reset", 32'(|code), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table-driven runs over all modes and masks
        for (int v = 0; v < NV; v++) run_vec(V_MODE[v], V_SEL[v], V_TGT[v]);

        // R9: start with empty mask is ignored
        @(negedge clk);
        start = 1'b1;
        chan_sel = '0;
        cmp = '1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 empty mask no ramp", 32'(ramp_go), 32'd0);
        @(negedge clk);
        chk("R9 empty mask done kept", 32'(done), 32'(exp_done));
        check_codes('0, 2047);

        // R4 glitches and pre-high comparator, R9 busy start, 8-bit run on channel 0
        cmp = 8'b0000_0010;
        chan_sel = 2'b01;
        res_mode = 2'b10;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chan_sel = '0;
        for (int cyc = 0; cyc <= 255; cyc++) begin
            if (cyc > 0) @(negedge clk);
            cmp[0] = ((cyc >= 10) && (cyc < 12)) || (cyc >= 20);
            cmp[1] = 1'b1;
            cmp[2] = (cyc == 30) || (cyc == 40);
            cmp[7:4] = 4'b1111;
            if (cyc == 50) begin
                start = 1'b1;
                chan_sel = 2'b10;
                res_mode = 2'b00;
            end
            if (cyc == 51) begin
                start = 1'b0;
                chan_sel = '0;
                chk("R9 busy start ignored", 32'(ramp_go), 32'b01);
                chk("R9 busy start done kept", 32'(done[1]), 32'(exp_done[1]));
            end
            if (cyc == 255) chk("R9 run length unchanged", 32'(done[0]), 32'd0);
        end
        @(negedge clk);
        chk("R9 finishes at 8-bit length", 32'(done), 32'(exp_done | 2'b01));
        exp_code[0] = gray(10);
        exp_code[1] = gray(255);
        exp_code[2] = gray(30);
        exp_code[3] = gray(255);
        exp_done = exp_done | 2'b01;
        chk("R4 first edge kept after glitch", 32'(code[0 +: CW]), 32'(gray(10)));
        chk("R4 pre-high comparator not an edge", 32'(code[CW +: CW]), 32'(gray(255)));
        chk("R4 second pulse ignored", 32'(code[2*CW +: CW]), 32'(gray(30)));
        chk("R5 silent cell full scale", 32'(code[3*CW +: CW]), 32'(gray(255)));
        check_codes(2'b01, 255);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule